// File: doc/BRIEF.md
# Don't-Care Vote Tally Engine

This block watches the stream of input vectors that reach one k-input look-up table and picks a value for every truth-table entry that is marked as a don't-care. A configuration truth table and a care mask describe the table. Each qualified input vector is classed either as a care state, whose output value is known, or as a don't-care occurrence. A don't-care occurrence is counted as pending against its own entry. When the next care state arrives, the pending occurrences become votes only if that care value equals the value of the care state that came before them. The shared value is the value they vote for. Otherwise they are dropped.

Every don't-care entry keeps two saturating tallies, one for votes toward 0 and one for votes toward 1. A finalize command captures a resolved truth table. In that table each don't-care entry takes its majority value, a tie takes a configurable default bit, and every care entry keeps its configured value. A per-entry bias figure (the larger tally and the sum of both tallies) is always visible, so a confidence ratio can be formed outside the block. A clear command restarts the analysis in one cycle.

Top module: `dcv_vote_engine`

## Requirements
- R1: Vectors are taken one per cycle while `vec_valid` is high, in arrival order. Cycles with `vec_valid` low change no state. The entry index of a vector is its binary value, and bit e of `cfg_care` / `cfg_table` describes entry e (care when 1).
- R2: A don't-care vector that arrives after a care state adds one pending occurrence to its own entry. A don't-care vector that arrives before any care state since reset or clear adds nothing.
- R3: When a care vector arrives and a previous care state exists, each entry's pending count is handled in one of two ways. If the two care values are equal, the count is added to that entry's tally for that value. If they differ, the count is discarded. In both cases all pending counts return to zero.
- R4: Each entry keeps independent tallies for 0 and for 1, and a vote for one value never changes the other tally or any other entry.
- R5: In the resolved table a don't-care entry is 1 when its 1-tally exceeds its 0-tally and 0 in the opposite case. A tie, including zero votes, yields `DEFAULT_BIT`.
- R6: In the resolved table every care entry equals its `cfg_table` bit.
- R7: Tallies saturate at 2^VW-1 and pending counts saturate at 2^PW-1. Neither ever wraps.
- R8: `bias_major[e*VW +: VW]` shows the larger tally of entry e and `bias_total[e*(VW+1) +: VW+1]` shows the sum of its two tallies. Both follow the tallies one cycle after the vector that changed them.
- R9: `clr` zeroes all tallies and pending counts and forgets the previous care state in one cycle. It takes priority over a vector and over `finalize` in the same cycle (no `done` follows).
- R10: `finalize` produces `done` high for exactly the next cycle, with `res_table` formed from the tallies as they stood before that cycle's vector. Occurrences still pending at that point cast no vote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Restart the tally in one cycle |
| cfg_table | input | 2**K | Configured output value per entry |
| cfg_care | input | 2**K | 1 marks a care entry, 0 a don't-care |
| vec_valid | input | 1 | Qualifies `vec` |
| vec | input | K | Local input vector of the table |
| finalize | input | 1 | Request a resolved table |
| done | output | 1 | One-cycle strobe, `res_table` valid |
| res_table | output | 2**K | Resolved truth table |
| bias_major | output | 2**K*VW | Larger tally per entry |
| bias_total | output | 2**K*(VW+1) | Sum of both tallies per entry |

## Verification
The hardest situations to reach from the ports are saturation, both of a pending count and of a tally that receives a large pending batch in one step. With narrow bench parameters (3-bit tallies, 4-bit pending), twenty don't-care hits between two agreeing care states fill the pending counter and then overflow the tally in one flush. Repeated hit/care pairs drive another tally to its ceiling. Disagreeing neighbours, occurrences before the first care state, occurrences left pending at finalize, and clear or finalize in the same cycle as a vector are each forced by explicit short sequences. A reference model built from the requirements predicts every bias figure and every resolved table.

// File: rtl/dcv_pkg.sv
package dcv_pkg;

   // Event raised by the care tracker when a care state closes a window
   typedef struct packed {
      logic flush;   // a care state arrived and a previous one exists
      logic agree;   // its value equals the previous care value
      logic val;     // its value
   } care_evt_t;

endpackage

// File: rtl/dcv_care_tracker.sv
module dcv_care_tracker
   import dcv_pkg::*;
#(
   parameter int K = 4,
   localparam int N = 1 << K
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         vec_valid,
   input  logic [K-1:0] vec,
   input  logic [N-1:0] cfg_table,
   input  logic [N-1:0] cfg_care,
   output care_evt_t    evt,
   output logic [N-1:0] hit
);

   logic have_prev;
   logic prev_val;
   logic is_care;
   logic cur_val;

   assign is_care = cfg_care[vec];
   assign cur_val = cfg_table[vec];

   always_comb begin
      evt.flush = vec_valid & is_care & have_prev & ~clr;
      evt.agree = (prev_val == cur_val);
      evt.val   = cur_val;
      hit       = '0;
      if (vec_valid && !is_care && have_prev && !clr)
         hit[vec] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_val  <= 1'b0;
      end else if (clr) begin
         have_prev <= 1'b0;
         prev_val  <= 1'b0;
      end else if (vec_valid && is_care) begin
         have_prev <= 1'b1;
         prev_val  <= cur_val;
      end
   end

   assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   assert_clear_forgets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (hit == '0) && !evt.flush);

endmodule

// File: rtl/dcv_entry_tally.sv
module dcv_entry_tally
   import dcv_pkg::*;
#(
   parameter int   VW          = 8,
   parameter int   PW          = 8,
   parameter logic DEFAULT_BIT = 1'b0,
   localparam int  SW          = ((VW > PW) ? VW : PW) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   input  care_evt_t     evt,
   input  logic          care_bit,
   input  logic          val_bit,
   output logic          res_bit,
   output logic [VW-1:0] major,
   output logic [VW:0]   total
);

   localparam logic [SW-1:0] CEIL = {{(SW-VW){1'b0}}, {VW{1'b1}}};

   logic [PW-1:0] pend;
   logic [VW-1:0] cnt0, cnt1;
   logic [SW-1:0] sum0, sum1;
   logic [VW-1:0] nxt0, nxt1;

   assign sum0 = {{(SW-VW){1'b0}}, cnt0} + {{(SW-PW){1'b0}}, pend};
   assign sum1 = {{(SW-VW){1'b0}}, cnt1} + {{(SW-PW){1'b0}}, pend};
   assign nxt0 = (sum0 > CEIL) ? {VW{1'b1}} : sum0[VW-1:0];
   assign nxt1 = (sum1 > CEIL) ? {VW{1'b1}} : sum1[VW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         cnt0 <= '0;
         cnt1 <= '0;
      end else if (clr) begin
         pend <= '0;
         cnt0 <= '0;
         cnt1 <= '0;
      end else if (evt.flush) begin
         pend <= '0;
         if (evt.agree && !evt.val) cnt0 <= nxt0;
         if (evt.agree &&  evt.val) cnt1 <= nxt1;
      end else if (hit && (pend != {PW{1'b1}})) begin
         pend <= pend + 1'b1;
      end
   end

   always_comb begin
      major = (cnt1 > cnt0) ? cnt1 : cnt0;
      total = {1'b0, cnt0} + {1'b0, cnt1};
      if (care_bit)          res_bit = val_bit;
      else if (cnt1 > cnt0)  res_bit = 1'b1;
      else if (cnt0 > cnt1)  res_bit = 1'b0;
      else                   res_bit = DEFAULT_BIT;
   end

   assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt0 >= $past(cnt0)) && (cnt1 >= $past(cnt1)));

   assert_pending_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.flush && !clr) |=> (pend == '0));

   assert_votes_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.flush && !clr) |=> $stable(cnt0) && $stable(cnt1));

endmodule

// File: rtl/dcv_vote_engine.sv
module dcv_vote_engine
   import dcv_pkg::*;
#(
   parameter int   K           = 4,
   parameter int   VW          = 8,
   parameter int   PW          = 8,
   parameter logic DEFAULT_BIT = 1'b0,
   localparam int  N           = 1 << K
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [N-1:0]      cfg_table,
   input  logic [N-1:0]      cfg_care,
   input  logic              vec_valid,
   input  logic [K-1:0]      vec,
   input  logic              finalize,
   output logic              done,
   output logic [N-1:0]      res_table,
   output logic [N*VW-1:0]   bias_major,
   output logic [N*(VW+1)-1:0] bias_total
);

   generate
      if (K < 1 || K > 8) begin : g_bad_k
         $error("dcv_vote_engine: K must lie in 1..8");
      end
      if (VW < 1 || PW < 1) begin : g_bad_w
         $error("dcv_vote_engine: VW and PW must be at least 1");
      end
   endgenerate

   care_evt_t    evt;
   logic [N-1:0] hit;
   logic [N-1:0] res_live;

   dcv_care_tracker #(.K(K)) i_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .vec_valid (vec_valid),
      .vec       (vec),
      .cfg_table (cfg_table),
      .cfg_care  (cfg_care),
      .evt       (evt),
      .hit       (hit)
   );

   for (genvar e = 0; e < N; e++) begin : g_entry
      dcv_entry_tally #(.VW(VW), .PW(PW), .DEFAULT_BIT(DEFAULT_BIT)) i_tally (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .hit      (hit[e]),
         .evt      (evt),
         .care_bit (cfg_care[e]),
         .val_bit  (cfg_table[e]),
         .res_bit  (res_live[e]),
         .major    (bias_major[e*VW +: VW]),
         .total    (bias_total[e*(VW+1) +: VW+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         res_table <= '0;
      end else begin
         done <= finalize & ~clr;
         if (finalize && !clr) res_table <= res_live;
      end
   end

   assert_care_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (finalize && !clr && $stable(cfg_care) && $stable(cfg_table))
         |=> ((res_table & cfg_care) == (cfg_table & cfg_care)));

   assert_clear_blocks_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !done);

endmodule

// File: tb/test_dcv_vote_engine.sv
module test_dcv_vote_engine;

   localparam int   K   = 3;
   localparam int   N   = 1 << K;
   localparam int   VW  = 3;
   localparam int   PW  = 4;
   localparam logic DEF = 1'b1;
   localparam int   VMAX = (1 << VW) - 1;
   localparam int   PMAX = (1 << PW) - 1;

   // care entries 1,2,5,7 ; values entry1=0 entry2=1 entry5=0 entry7=1
   localparam logic [N-1:0] CARE = 8'b1010_0110;
   localparam logic [N-1:0] TBL  = 8'b1000_0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic vec_valid = 1'b0;
   logic [K-1:0] vec = '0;
   logic finalize = 1'b0;
   logic done;
   logic [N-1:0] res_table;
   logic [N*VW-1:0] bias_major;
   logic [N*(VW+1)-1:0] bias_total;

   always #4 clk = ~clk;

   dcv_vote_engine #(.K(K), .VW(VW), .PW(PW), .DEFAULT_BIT(DEF)) i_dcv_vote_engine (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_table(TBL), .cfg_care(CARE),
      .vec_valid(vec_valid), .vec(vec), .finalize(finalize), .done(done),
      .res_table(res_table), .bias_major(bias_major), .bias_total(bias_total));

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // reference model built from the requirements
   int  m_c0 [N];
   int  m_c1 [N];
   int  m_pend [N];
   bit  m_have;
   bit  m_prev;
   logic [N-1:0] exp_q [$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   function automatic logic [N-1:0] model_table();
      logic [N-1:0] t;
      for (int e = 0; e < N; e++) begin
         if (CARE[e])                t[e] = TBL[e];
         else if (m_c1[e] > m_c0[e]) t[e] = 1'b1;
         else if (m_c0[e] > m_c1[e]) t[e] = 1'b0;
         else                        t[e] = DEF;
      end
      return t;
   endfunction

   task automatic model_clear();
      for (int e = 0; e < N; e++) begin
         m_c0[e] = 0; m_c1[e] = 0; m_pend[e] = 0;
      end
      m_have = 1'b0;
      m_prev = 1'b0;
   endtask

   // driver: called at a falling edge, applies one cycle of stimulus
   task automatic cyc(input bit c, input bit f, input bit vv, input int v);
      clr = c; finalize = f; vec_valid = vv; vec = K'(v);
      if (c) model_clear();
      else begin
         if (f) exp_q.push_back(model_table());
         if (vv) begin
            if (CARE[v]) begin
               if (m_have)
                  for (int e = 0; e < N; e++) begin
                     if (m_prev == TBL[v]) begin
                        if (TBL[v]) m_c1[e] = (m_c1[e] + m_pend[e] > VMAX) ? VMAX : m_c1[e] + m_pend[e];
                        else        m_c0[e] = (m_c0[e] + m_pend[e] > VMAX) ? VMAX : m_c0[e] + m_pend[e];
                     end
                     m_pend[e] = 0;
                  end
               m_have = 1'b1;
               m_prev = TBL[v];
            end else if (m_have && m_pend[v] < PMAX) begin
               m_pend[v]++;
            end
         end
      end
      @(negedge clk);
      clr = 1'b0; finalize = 1'b0; vec_valid = 1'b0;
      if (f && !c) chk(done === 1'b1, "R10 done after finalize", done, 1);
   endtask

   task automatic put(input int v);
      cyc(1'b0, 1'b0, 1'b1, v);
   endtask

   task automatic check_bias(input string tag);
      for (int e = 0; e < N; e++) begin
         int mj;
         mj = (m_c1[e] > m_c0[e]) ? m_c1[e] : m_c0[e];
         chk(int'(bias_major[e*VW +: VW]) == mj, {tag, " major"}, int'(bias_major[e*VW +: VW]), mj);
         chk(int'(bias_total[e*(VW+1) +: VW+1]) == m_c0[e] + m_c1[e], {tag, " total"},
             int'(bias_total[e*(VW+1) +: VW+1]), m_c0[e] + m_c1[e]);
      end
   endtask

   // monitor: pops an expected table for every done strobe
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
         else begin
            logic [N-1:0] ex;
            ex = exp_q.pop_front();
            chk(res_table === ex, "R5 R6 resolved table", int'(res_table), int'(ex));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      chk(done === 1'b0, "R9 reset done", done, 0);
      chk(res_table === '0, "R9 reset table", int'(res_table), 0);
      chk(bias_total === '0, "R9 reset totals", 0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: don't-cares before the first care state are dropped
      put(0); put(3);
      put(1);                     // care value 0
      put(0);                     // pending on entry 0
      cyc(1'b0, 1'b0, 1'b0, 0);   // R1: idle cycle, no effect
      cyc(1'b0, 1'b0, 1'b0, 4);   // R1: vec without valid ignored
      put(5);                     // care value 0 -> entry0 gets a 0-vote
      check_bias("R2 R3 agree");
      chk(int'(bias_total[0 +: VW+1]) == 1, "R2 entry0 one vote", int'(bias_total[0 +: VW+1]), 1);
      chk(int'(bias_total[3*(VW+1) +: VW+1]) == 0, "R2 early dc ignored", int'(bias_total[3*(VW+1) +: VW+1]), 0);

      // R3: disagreeing neighbours discard
      put(3); put(3); put(2);     // 0 -> 1
      check_bias("R3 disagree");
      chk(int'(bias_total[3*(VW+1) +: VW+1]) == 0, "R3 discarded", int'(bias_total[3*(VW+1) +: VW+1]), 0);

      // R4: a batch of three 1-votes to entry 4 only
      put(4); put(4); put(4); put(7);
      check_bias("R4 batch");
      chk(int'(bias_major[4*VW +: VW]) == 3, "R4 entry4 ones", int'(bias_major[4*VW +: VW]), 3);

      // R7: repeated agreeing pairs saturate entry 6
      for (int i = 0; i < 10; i++) begin put(6); put(7); end
      check_bias("R7 tally ceiling");
      chk(int'(bias_major[6*VW +: VW]) == VMAX, "R7 entry6 saturated", int'(bias_major[6*VW +: VW]), VMAX);

      // R7: pending saturation then batch overflow on entry 0 (1-votes)
      for (int i = 0; i < 20; i++) put(0);
      put(2);
      check_bias("R7 pending ceiling");
      chk(int'(bias_total[0 +: VW+1]) == 1 + VMAX, "R8 entry0 total", int'(bias_total[0 +: VW+1]), 1 + VMAX);

      // R10 / R5: finalize, tie on entry 3 gives the default
      cyc(1'b0, 1'b1, 1'b0, 0);
      // R10: pending at finalize casts no vote
      put(3);
      cyc(1'b0, 1'b1, 1'b0, 0);
      chk(res_table[3] === DEF, "R10 pending not counted", int'(res_table[3]), int'(DEF));
      // R10: vector on the finalize cycle is excluded
      put(5); put(5);             // 1 -> 0 closes entry3 window (discard), then 0
      put(3);
      cyc(1'b0, 1'b1, 1'b1, 1);   // care 0 agrees; vote lands after the snapshot
      chk(res_table[3] === DEF, "R10 same-cycle vector excluded", int'(res_table[3]), int'(DEF));
      cyc(1'b0, 1'b1, 1'b0, 0);
      chk(res_table[3] === 1'b0, "R5 majority zero", int'(res_table[3]), 0);

      // R9: clear with vector and finalize in the same cycle
      put(6);
      cyc(1'b1, 1'b1, 1'b1, 1);
      chk(done === 1'b0, "R9 no done on clear", done, 0);
      check_bias("R9 cleared");
      put(6); put(7);             // first care after clear: nothing pending
      check_bias("R9 neighbour forgotten");
      cyc(1'b0, 1'b1, 1'b0, 0);
      chk(res_table === ((TBL & CARE) | (~CARE & {N{DEF}})), "R6 R5 fresh table",
          int'(res_table), int'((TBL & CARE) | (~CARE & {N{DEF}})));

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R10 every finalize answered", exp_q.size(), 0);
      finished = 1'b1;
      summary();
   end

endmodule